// File: doc/BRIEF.md
# Flash Word Write Sequencer

This block sits on the host side of a command-driven flash device and drives its automated programming flow. The host hands over one request at a time: a byte or word write, a status check, a status clear, or a return to array-read mode. For a write the sequencer issues two bus writes to the target location: first the program-setup command, then the data. It then reads the device status repeatedly until the device reports ready, and reports the outcome as a 2-bit result code.

Each read of the status is a fresh output-enable pulse, because the device only updates its status on a new read strobe. In the narrow (x8) mode only the low byte lane carries commands and status. In the wide (x16) mode every command byte is copied to both lanes, addresses count words instead of bytes, and both lanes must report ready before the write is treated as finished. The full error check can run after every write, or only once at the end of a burst through a separate check request, because the device keeps its error flags set until it is told to clear them. A failure caused by a low programming voltage locks out further writes until the host issues a clear.

Top module: `flash_wr_seq`

## Requirements
- R1: A write request (op code 00) causes exactly two bus writes (`fl_we` high), in two consecutive cycles, to the request address. The first carries 0x40, or 0x4040 in x16 mode. The second carries the request data, with the upper byte forced to zero in x8 mode.
- R2: After the data write the block polls with single-cycle `fl_oe` pulses, one every two cycles. It samples `fl_rdata` in the cycle after each pulse and stops once status bit 7 is 1 (in x16 mode, bits 7 and 15 must both be 1). `fl_we` and `fl_oe` are never high together.
- R3: In x8 mode the upper status byte (bits 15..8) has no effect on readiness or on the result.
- R4: When the check flag (`req_chk`) is set and the device is ready, status bit 3 (bit 3 or 11 in x16) gives result 01. This fault takes precedence over a write error.
- R5: Under the same conditions, status bit 4 (bit 4 or 12 in x16) without a voltage fault gives result 10. With neither bit set the result is 00.
- R6: With the check flag clear, a write that reaches ready reports 00 whatever the error bits say.
- R7: When the device is still busy after POLL_LIMIT status reads, the result is 11 and no further read is issued.
- R8: A check request (op code 01) makes no bus write. It polls and judges the error bits as in R2, R4 and R5, so that errors left over from earlier unchecked writes are reported.
- R9: After any result 01 from a polled operation, every write request is answered with 01 one cycle after acceptance, with no bus activity, until a clear request is completed.
- R10: A clear request (op code 10) makes one bus write of 0x50 (0x5050 in x16) to the request address, answers 00, and ends the lockout of R9.
- R11: A read-array request (op code 11) makes one bus write of 0xFF (0xFFFF in x16) to the request address and answers 00.
- R12: `ack` is a one-cycle pulse, and `ack_res` is valid in that cycle. Counting clock edges from the first edge that sees `req`, the ack cycle begins at edge 2k+3 for a write with k status reads, 2k+1 for a check, 2 for a clear or read-array, and 1 for a rejected write. Out of reset `ack`, `fl_we` and `fl_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request; held until the ack cycle, dropped in that cycle |
| req_op | input | 2 | 00 write, 01 check, 10 clear status, 11 read-array |
| req_x16 | input | 1 | 1 selects the wide word mode |
| req_chk | input | 1 | Judge the error bits after a write |
| req_addr | input | ADDR_W | Target byte or word address |
| req_data | input | 16 | Data to program |
| ack | output | 1 | One-cycle completion pulse |
| ack_res | output | 2 | 00 ok, 01 voltage fault, 10 write error, 11 timeout |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | 16 | Flash bus write data |
| fl_we | output | 1 | Flash bus write strobe, one cycle per write |
| fl_oe | output | 1 | Flash status read strobe |
| fl_rdata | input | 16 | Status from the device, valid the cycle after `fl_oe` |

## Verification
Every result is due at a fixed cycle once the number of status reads k is known: 2k+3 cycles after the request for a write, 2k+1 for a check, 2 for a clear or read-array, and 1 for a rejected write. The bench works out k from the busy time and lane lag it programs into its device model, capped at POLL_LIMIT. It counts falling edges from the request until `ack` and compares that count with the expected figure. It also compares the number of bus writes and reads logged by the model against the expected counts, so a stray or missing strobe is caught as well as a late or early acknowledge.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int LANE_W = 8;
  localparam int NLANES = 2;
  localparam int DATA_W = LANE_W * NLANES;

  // status bit positions inside one byte lane
  localparam int SR_RDY  = 7;
  localparam int SR_VPP  = 3;
  localparam int SR_WERR = 4;

  localparam logic [LANE_W-1:0] CODE_SETUP = 8'h40;
  localparam logic [LANE_W-1:0] CODE_CLEAR = 8'h50;
  localparam logic [LANE_W-1:0] CODE_RDARR = 8'hFF;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_CHECK = 2'b01,
    OP_CLEAR = 2'b10,
    OP_RDARR = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_VPP  = 2'b01,
    RES_WERR = 2'b10,
    RES_TMO  = 2'b11
  } res_e;

  // copy one command byte onto every lane
  function automatic logic [DATA_W-1:0] dup_code(input logic [LANE_W-1:0] code);
    return {NLANES{code}};
  endfunction

  // outcome of a ready status; voltage fault wins over write error
  function automatic res_e judge(input logic chk, input logic vpp, input logic werr);
    if (!chk)      return RES_OK;
    else if (vpp)  return RES_VPP;
    else if (werr) return RES_WERR;
    else           return RES_OK;
  endfunction
endpackage

// File: rtl/fseq_lane_fmt.sv
module fseq_lane_fmt
  import fseq_pkg::*;
(
  input  logic              x16,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] word
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign word[g*LANE_W +: LANE_W] = val[g*LANE_W +: LANE_W];
    end else begin : g_upper
      assign word[g*LANE_W +: LANE_W] = x16 ? val[g*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/fseq_status_eval.sv
module fseq_status_eval
  import fseq_pkg::*;
(
  input  logic              x16,
  input  logic [DATA_W-1:0] sr,
  output logic              ready,
  output logic              vpp,
  output logic              werr
);
  logic [NLANES-1:0] act, rdy, v, w;
  logic unused_sr;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign act[g] = (g == 0) ? 1'b1 : x16;
    assign rdy[g] = sr[g*LANE_W + SR_RDY];
    assign v[g]   = sr[g*LANE_W + SR_VPP];
    assign w[g]   = sr[g*LANE_W + SR_WERR];
  end

  assign ready     = &(rdy | ~act);
  assign vpp       = |(v & act);
  assign werr      = |(w & act);
  assign unused_sr = ^sr;
endmodule

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign expire = tick && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/fseq_lock.sv
module fseq_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (!rst_n)   locked <= 1'b0;
    else if (clr) locked <= 1'b0;
    else if (set) locked <= 1'b1;
  end
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int POLL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        req_op,
  input  logic              req_x16,
  input  logic              req_chk,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  output logic              ack,
  output logic [1:0]        ack_res,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [15:0]       fl_wdata,
  output logic              fl_we,
  output logic              fl_oe,
  input  logic [15:0]       fl_rdata
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_DATA, ST_CMD, ST_RD, ST_SMP, ST_DONE
  } st_e;

  st_e               state, state_nx;
  op_e               op_q;
  logic              x16_q, chk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  res_e              res_q;

  // named events, also watched by the checker
  logic accept, ev_reject, ev_setup, ev_data, ev_cmd, ev_sample;
  logic ev_ready, ev_busy, ev_timeout, ev_vpp_fail, ev_unlock;
  logic sr_ready, sr_vpp, sr_werr, expire, locked;
  logic [DATA_W-1:0] wr_val;

  assign accept      = (state == ST_IDLE) && req;
  assign ev_reject   = accept && (op_e'(req_op) == OP_WRITE) && locked;
  assign ev_setup    = (state == ST_SETUP);
  assign ev_data     = (state == ST_DATA);
  assign ev_cmd      = (state == ST_CMD);
  assign ev_sample   = (state == ST_SMP);
  assign ev_ready    = ev_sample && sr_ready;
  assign ev_busy     = ev_sample && !sr_ready;
  assign ev_timeout  = ev_busy && expire;
  assign ev_vpp_fail = ev_ready && chk_q && sr_vpp;
  assign ev_unlock   = ev_cmd && (op_q == OP_CLEAR);

  fseq_status_eval u_eval (
    .x16   (x16_q),
    .sr    (fl_rdata),
    .ready (sr_ready),
    .vpp   (sr_vpp),
    .werr  (sr_werr)
  );

  fseq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .tick   (ev_busy),
    .expire (expire)
  );

  fseq_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (ev_vpp_fail),
    .clr    (ev_unlock),
    .locked (locked)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (ev_reject) state_nx = ST_DONE;
          else begin
            unique case (op_e'(req_op))
              OP_WRITE: state_nx = ST_SETUP;
              OP_CHECK: state_nx = ST_RD;
              default:  state_nx = ST_CMD;
            endcase
          end
        end
      end
      ST_SETUP: state_nx = ST_DATA;
      ST_DATA:  state_nx = ST_RD;
      ST_RD:    state_nx = ST_SMP;
      ST_SMP: begin
        if (sr_ready || expire) state_nx = ST_DONE;
        else                    state_nx = ST_RD;
      end
      ST_CMD:  state_nx = ST_DONE;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_WRITE;
      x16_q  <= 1'b0;
      chk_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      res_q  <= RES_OK;
    end else begin
      state <= state_nx;
      if (accept) begin
        op_q   <= op_e'(req_op);
        x16_q  <= req_x16;
        chk_q  <= req_chk || (op_e'(req_op) == OP_CHECK);
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (ev_reject)       res_q <= RES_VPP;
      else if (ev_ready)   res_q <= judge(chk_q, sr_vpp, sr_werr);
      else if (ev_timeout) res_q <= RES_TMO;
      else if (ev_cmd)     res_q <= RES_OK;
    end
  end

  always_comb begin
    wr_val = '0;
    if (ev_setup)                  wr_val = dup_code(CODE_SETUP);
    else if (ev_data)              wr_val = data_q;
    else if (ev_cmd && ev_unlock)  wr_val = dup_code(CODE_CLEAR);
    else if (ev_cmd)               wr_val = dup_code(CODE_RDARR);
  end

  fseq_lane_fmt u_fmt (
    .x16  (x16_q),
    .val  (wr_val),
    .word (fl_wdata)
  );

  assign fl_we   = ev_setup || ev_data || ev_cmd;
  assign fl_oe   = (state == ST_RD);
  assign fl_addr = addr_q;
  assign ack     = (state == ST_DONE);
  assign ack_res = res_q;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int ADDR_W     = 20,
  parameter int POLL_LIMIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_we,
  input logic              fl_oe,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              ack,
  input logic [1:0]        ack_res,
  input logic              ev_setup,
  input logic              ev_data,
  input logic              ev_reject,
  input logic              ev_timeout,
  input logic              locked
);
  int rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_cnt <= 0;
    else if (ack)   rd_cnt <= 0;
    else if (fl_oe) rd_cnt <= rd_cnt + 1;
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      AST_POLL_BOUND: assert (rd_cnt <= POLL_LIMIT); // R7
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fl_we && fl_oe)); // R2
  AST_OE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fl_oe |=> !fl_oe); // R2
  AST_SETUP_DATA: assert property (@(posedge clk) disable iff (!rst_n) ev_setup |=> (ev_data && fl_we && $stable(fl_addr))); // R1
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R12
  AST_REJECT_RES: assert property (@(posedge clk) disable iff (!rst_n) ev_reject |=> (ack && ack_res == 2'b01 && !fl_we)); // R9
  AST_TMO_RES: assert property (@(posedge clk) disable iff (!rst_n) ev_timeout |=> (ack && ack_res == 2'b11 && !fl_oe)); // R7
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (locked && !fl_we) |=> locked); // R9
endmodule

bind flash_wr_seq fseq_checker #(.ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fl_we      (fl_we),
  .fl_oe      (fl_oe),
  .fl_addr    (fl_addr),
  .ack        (ack),
  .ack_res    (ack_res),
  .ev_setup   (ev_setup),
  .ev_data    (ev_data),
  .ev_reject  (ev_reject),
  .ev_timeout (ev_timeout),
  .locked     (locked)
);

// File: tb/test_flash_wr_seq.sv
`timescale 1ns/1ps
module test_flash_wr_seq;
  localparam int AW = 20;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic req_x16 = 1'b0, req_chk = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic ack, fl_we, fl_oe;
  logic [1:0] ack_res;
  logic [AW-1:0] fl_addr;
  logic [15:0] fl_wdata;
  logic [15:0] fl_rdata = '0;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  flash_wr_seq #(.ADDR_W(AW), .POLL_LIMIT(LIM)) i_flash_wr_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_x16(req_x16),
    .req_chk(req_chk), .req_addr(req_addr), .req_data(req_data), .ack(ack),
    .ack_res(ack_res), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
    .fl_oe(fl_oe), .fl_rdata(fl_rdata)
  );

  // ---------------- device model ----------------
  int inj_busy = 0, inj_lag = 0;
  logic inj_vlo = 0, inj_vhi = 0, inj_wlo = 0, inj_whi = 0;
  int busy_lo = 0, busy_hi = 0;
  logic e_vlo = 0, e_vhi = 0, e_wlo = 0, e_whi = 0;
  logic armed = 0;
  int nwr = 0, nrd = 0;
  logic [AW-1:0] log_a [256];
  logic [15:0]   log_d [256];

  always @(posedge clk) begin
    if (fl_we) begin
      log_a[nwr % 256] <= fl_addr;
      log_d[nwr % 256] <= fl_wdata;
      nwr <= nwr + 1;
      if (armed) begin
        armed   <= 1'b0;
        busy_lo <= inj_busy;
        busy_hi <= inj_busy + inj_lag;
        e_vlo <= e_vlo | inj_vlo;  e_vhi <= e_vhi | inj_vhi;
        e_wlo <= e_wlo | inj_wlo;  e_whi <= e_whi | inj_whi;
      end else if (fl_wdata[7:0] == 8'h40) begin
        armed <= 1'b1;
      end else if (fl_wdata[7:0] == 8'h50) begin
        e_vlo <= 0; e_vhi <= 0; e_wlo <= 0; e_whi <= 0;
      end
    end
    if (fl_oe) begin
      fl_rdata <= {busy_hi == 0, 2'b00, e_whi, e_vhi, 3'b000,
                   busy_lo == 0, 2'b00, e_wlo, e_vlo, 3'b000};
      nrd <= nrd + 1;
      busy_lo <= (busy_lo > 0) ? busy_lo - 1 : 0;
      busy_hi <= (busy_hi > 0) ? busy_hi - 1 : 0;
    end
  end

  // ---------------- checking helpers ----------------
  logic lock_exp = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lane(input logic x16, input logic [15:0] v);
    return x16 ? v : {8'h00, v[7:0]};
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_judge(input logic chk, input logic vp, input logic we);
    if (!chk) return 0;
    if (vp)   return 1;
    if (we)   return 2;
    return 0;
  endfunction

  task automatic do_op(input logic [1:0] op, input logic x16, input logic chk,
                       input logic [AW-1:0] addr, input logic [15:0] data,
                       input int b, input int l,
                       input logic vlo, input logic vhi, input logic wlo, input logic whi);
    int k, res, lat, wr, need, bl, bh, w0, r0, cyc;
    logic vp, we, polled, jchk;
    string tag;
    inj_busy = b; inj_lag = l;
    inj_vlo = vlo; inj_vhi = vhi; inj_wlo = wlo; inj_whi = whi;
    k = 0; res = 0; wr = 0; lat = 2; polled = 0; tag = "R2"; jchk = chk;
    if (op == 2'b00 && lock_exp) begin
      res = 1; lat = 1; tag = "R9";
    end else if (op == 2'b00 || op == 2'b01) begin
      polled = 1;
      if (op == 2'b00) begin
        bl = b; bh = b + l; wr = 2;
        vp = e_vlo | vlo | (x16 & (e_vhi | vhi));
        we = e_wlo | wlo | (x16 & (e_whi | whi));
      end else begin
        bl = busy_lo; bh = busy_hi; jchk = 1; tag = "R8";
        vp = e_vlo | (x16 & e_vhi);
        we = e_wlo | (x16 & e_whi);
      end
      need = (x16 ? imax(bl, bh) : bl) + 1;
      if (need > LIM) begin
        k = LIM; res = 3; tag = "R7";
      end else begin
        k = need; res = exp_judge(jchk, vp, we);
        if (op == 2'b00 && res == 1) tag = "R4";
        if (op == 2'b00 && res == 2) tag = "R5";
        if (op == 2'b00 && !chk)     tag = "R6";
      end
      lat = (op == 2'b00) ? 2 * k + 3 : 2 * k + 1;
    end else begin
      wr = 1; tag = (op == 2'b10) ? "R10" : "R11";
    end

    w0 = nwr; r0 = nrd;
    req_op = op; req_x16 = x16; req_chk = chk; req_addr = addr; req_data = data;
    req = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ack && cyc < 4000);
    req = 1'b0;
    check(tag, "result", ack_res, res);
    check("R12", "ack latency", cyc, lat);
    check(tag, "bus writes", nwr - w0, wr);
    check(tag, "status reads", nrd - r0, k);
    if (op == 2'b00 && wr == 2) begin
      check("R1", "setup data", log_d[w0 % 256], lane(x16, 16'h4040));
      check("R1", "setup addr", log_a[w0 % 256], addr);
      check("R1", "write data", log_d[(w0 + 1) % 256], lane(x16, data));
      check("R1", "write addr", log_a[(w0 + 1) % 256], addr);
    end
    if (op == 2'b10) check("R10", "clear code", log_d[w0 % 256], lane(x16, 16'h5050));
    if (op == 2'b11) check("R11", "read-array code", log_d[w0 % 256], lane(x16, 16'hFFFF));
    if (op == 2'b10) lock_exp = 1'b0;
    else if (polled && res == 1) lock_exp = 1'b1;
    @(negedge clk);
    check("R12", "ack drops", ack, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "reset ack", ack, 0);
    check("R12", "reset we", fl_we, 0);
    check("R12", "reset oe", fl_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: plain x8 and x16 writes
    do_op(2'b00, 0, 1, 20'h00123, 16'hA5C3, 0, 0, 0, 0, 0, 0);
    do_op(2'b00, 1, 1, 20'h0ABCD, 16'h1234, 2, 2, 0, 0, 0, 0);
    // R3: x8 ignores upper-lane ready lag and upper-lane errors
    do_op(2'b00, 0, 1, 20'h00010, 16'h00EE, 1, 6, 0, 1, 0, 1);
    do_op(2'b10, 0, 0, 20'h00000, 16'h0000, 0, 0, 0, 0, 0, 0);
    // R5 write error on upper lane, R6 unchecked write, R8 burst check
    do_op(2'b00, 1, 1, 20'h00200, 16'hBEEF, 1, 0, 0, 0, 0, 1);
    do_op(2'b00, 1, 0, 20'h00201, 16'hCAFE, 0, 1, 0, 0, 0, 0);
    do_op(2'b01, 1, 0, 20'h00201, 16'h0000, 0, 0, 0, 0, 0, 0);
    do_op(2'b10, 1, 0, 20'h00000, 16'h0000, 0, 0, 0, 0, 0, 0);
    // R4 precedence, R9 lockout, R10 unlock
    do_op(2'b00, 1, 1, 20'h00300, 16'h5A5A, 0, 0, 1, 0, 1, 0);
    do_op(2'b00, 0, 1, 20'h00301, 16'h0011, 0, 0, 0, 0, 0, 0);
    do_op(2'b00, 1, 0, 20'h00302, 16'h0022, 0, 0, 0, 0, 0, 0);
    do_op(2'b10, 1, 0, 20'h00000, 16'h0000, 0, 0, 0, 0, 0, 0);
    do_op(2'b00, 0, 1, 20'h00303, 16'h0033, 0, 0, 0, 0, 0, 0);
    // R7 timeout then a check picks up the remaining busy time
    do_op(2'b00, 0, 1, 20'h00400, 16'h0044, 20, 0, 0, 0, 0, 0);
    do_op(2'b01, 0, 0, 20'h00400, 16'h0000, 0, 0, 0, 0, 0, 0);
    do_op(2'b00, 1, 1, 20'h00401, 16'h0045, 14, 1, 0, 0, 0, 0);
    // R11 return to array reading
    do_op(2'b11, 1, 0, 20'h00000, 16'h0000, 0, 0, 0, 0, 0, 0);

    void'($urandom(32'd7321));
    for (int i = 0; i < 120; i++) begin
      int r;
      logic [1:0] op;
      r = $urandom % 8;
      op = (r < 5) ? 2'b00 : (r == 5) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
      do_op(op, 1'($urandom), 1'($urandom), AW'($urandom), 16'($urandom),
            $urandom % 6, $urandom % 4,
            ($urandom % 10) == 0, ($urandom % 10) == 0,
            ($urandom % 8) == 0, ($urandom % 8) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule